// File: doc/BRIEF.md
# Coprocessor Memory Window with Read Prefetch

This block gives a 16-bit host a narrow window into the memory spaces of a coprocessor. The host programs a word address and a configuration word, then moves data through a single data register. A write to the data register becomes one memory write at once. Reads are prefetched. Setting the run bit of the configuration starts a burst that fills a small read FIFO from the selected space. Every later read of the data register pops one word, and the engine tops the FIFO up again while words of the burst remain.

A region field in the configuration chooses the target space: data memory, the peripheral register space, program memory, or an external bus-master port. The external port is touched only when its channel and direction settings agree with the access. The coprocessor side is a plain synchronous memory port. A request is presented for one cycle, and read data comes back on the following cycle. A one-cycle interrupt pulse tells the host that a write has completed or that read data is waiting.

Top module: `hdp_data_port`

## Requirements
- R1: After reset the address and configuration read back as 0, the status reads 16'h0100, `irq` is low and no memory request is made.
- R2: The host selects registers with `host_sel`: 0 is data, 1 is address, 2 is configuration and 3 is status. Configuration bits 14:12 pick the space as follows: code 0 is data (`mem_space` 0), code 1 is peripheral (`mem_space` 1, address cut to its low 11 bits), code 5 is program (`mem_space` 2) and code 7 is external (`mem_space` 3). With any other code an access makes no memory request and leaves the address unchanged.
- R3: With configuration bit 1 set, each access to a valid region adds one to the 16-bit address, and 16'hFFFF wraps to 0. With the bit clear, the address is left alone.
- R4: For the data, program and external spaces, `mem_addr` is `hi_addr` placed above the 16-bit address.
- R5: A configuration write with bit 4 set starts a burst. A configuration write with bit 4 clear stops the burst and empties the FIFO.
- R6: Status bits 3:2 are written through `host_sel` 3 and set the burst length: 0 gives 1 word, 1 gives 8, 2 gives 16 and 3 has no bound. Fetched words arrive in address order.
- R7: A read of the data register returns the oldest FIFO word and removes it. The FIFO refills while burst words remain. A read from an empty FIFO returns 0.
- R8: The status reads back bits 3:2 as written. Bits 0 and 6 are set when the FIFO holds data, bit 5 when it holds 16 words, and bit 8 is always 1. All other bits are 0.
- R9: The external space is accessed only when `xp_chan` is 0, `xp_dir` matches the access (1 for a write, 0 for a read) and `xp_unit` is not 3. A gated-off read yields 0, and the address still advances. For unit 0 (byte) a read keeps the low 8 bits with the upper byte zero. For unit 1 and unit 2 a read keeps the low 16 bits.
- R10: `irq` pulses for one cycle after a data write to a valid region, after a burst start, and after a data read that leaves the FIFO non-empty.
- R11: A data write raises `mem_req` with `mem_we` in the same cycle and carries `host_wdata` on `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | One-cycle interrupt pulse |
| hi_addr | input | HI_W | Upper address bits for wide spaces |
| xp_chan | input | 2 | External port channel setting |
| xp_dir | input | 1 | External port direction, 1 = write |
| xp_unit | input | 2 | External port unit size code |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_space | output | 2 | Target space |
| mem_addr | output | 16+HI_W | Memory word address |
| mem_unit | output | 2 | Unit size for the external space |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |

## Verification
The bench builds the block with its default values: four high-address bits and a 16-entry FIFO. With these values a single burst code fills the FIFO exactly, and another one overruns it, so the refill path runs under back-to-back pops. It sweeps all eight region codes and all four burst codes. The external port is driven through its gating combinations and unit sizes. The memory model returns an arithmetic pattern of space and address, so every popped word has a known expected value.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_STAT = 2'd3
    } host_sel_e;

    typedef enum logic [1:0] {
        SP_DATA = 2'd0,
        SP_PERI = 2'd1,
        SP_PROG = 2'd2,
        SP_EXT  = 2'd3
    } space_e;

    localparam int CFG_AUTOINC = 1;
    localparam int CFG_RUN     = 4;
    localparam int CFG_REG_LO  = 12;
    localparam int PERI_AW     = 11;
    localparam int BURST_W     = 5;
    localparam logic [1:0] UNIT_BYTE = 2'd0;
    localparam logic [1:0] UNIT_NONE = 2'd3;
    localparam logic [1:0] CODE_ENDLESS = 2'd3;

    typedef struct packed {
        logic        valid;
        logic        live;
        logic        narrow;
    } resp_t;

    function automatic logic [BURST_W-1:0] burst_words(input logic [1:0] code);
        case (code)
            2'd0:    return BURST_W'(1);
            2'd1:    return BURST_W'(8);
            2'd2:    return BURST_W'(16);
            default: return '0;
        endcase
    endfunction

    function automatic logic [15:0] fmt_read(input logic narrow, input logic [31:0] r);
        return narrow ? {8'h00, r[7:0]} : r[15:0];
    endfunction

    function automatic logic [15:0] pack_status(input logic has_data, input logic is_full,
                                                input logic [1:0] code);
        logic [15:0] s;
        s      = 16'h0100;
        s[0]   = has_data;
        s[6]   = has_data;
        s[5]   = is_full;
        s[3:2] = code;
        return s;
    endfunction

endpackage

// File: rtl/hdp_fifo.sv
module hdp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) store[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_fifo_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_pop_order_R7: assert property (@(posedge clk) disable iff (rst)
        (!flush && do_pop && !do_push) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/hdp_route.sv
module hdp_route import hdp_pkg::*; #(
    parameter int HI_W = 4,
    localparam int MAW = 16 + HI_W
) (
    input  logic [2:0]      region,
    input  logic [15:0]     addr,
    input  logic [HI_W-1:0] hi,
    input  logic            is_write,
    input  logic [1:0]      xp_chan,
    input  logic            xp_dir,
    input  logic [1:0]      xp_unit,
    output logic            hit,
    output logic            live,
    output space_e          space,
    output logic [MAW-1:0]  maddr
);
    always_comb begin
        hit   = 1'b1;
        live  = 1'b1;
        space = SP_DATA;
        case (region)
            3'd0: space = SP_DATA;
            3'd1: space = SP_PERI;
            3'd5: space = SP_PROG;
            3'd7: begin
                space = SP_EXT;
                live  = (xp_chan == 2'd0) && (xp_dir == is_write) && (xp_unit != UNIT_NONE);
            end
            default: begin
                hit  = 1'b0;
                live = 1'b0;
            end
        endcase
        if (space == SP_PERI) maddr = MAW'(addr[PERI_AW-1:0]);
        else                  maddr = {hi, addr};
    end
endmodule

// File: rtl/hdp_prefetch.sv
module hdp_prefetch import hdp_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       cancel,
    input  logic [1:0] code,
    input  logic       hold,
    input  logic       room,
    output logic       step,
    output logic       busy
);
    logic [BURST_W-1:0] left;
    logic               endless;

    assign busy = endless || (left != '0);
    assign step = busy && !hold && room;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            left    <= '0;
            endless <= 1'b0;
        end else if (start) begin
            left    <= burst_words(code);
            endless <= (code == CODE_ENDLESS);
        end else if (step && !endless) begin
            left <= left - 1'b1;
        end
    end

    assert_left_only_falls_R6: assert property (@(posedge clk) disable iff (rst)
        !start |=> left <= $past(left));

    assert_cancel_stops_R5: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !busy);

endmodule

// File: rtl/hdp_data_port.sv
module hdp_data_port import hdp_pkg::*; #(
    parameter int HI_W  = 4,
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [1:0]           host_sel,
    input  logic [15:0]          host_wdata,
    output logic [15:0]          host_rdata,
    output logic                 irq,
    input  logic [HI_W-1:0]      hi_addr,
    input  logic [1:0]           xp_chan,
    input  logic                 xp_dir,
    input  logic [1:0]           xp_unit,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [1:0]           mem_space,
    output logic [16+HI_W-1:0]   mem_addr,
    output logic [1:0]           mem_unit,
    output logic [15:0]          mem_wdata,
    input  logic [31:0]          mem_rdata
);
    localparam int MAW = 16 + HI_W;
    localparam int CW  = $clog2(DEPTH + 1);

    host_sel_e        sel;
    logic             wr_data, wr_addr, wr_cfg, wr_stat, rd_data;
    logic [15:0]      addr_q, cfg_q;
    logic [1:0]       code_q;
    logic             irq_q;
    logic             hit, live;
    space_e           space;
    logic [MAW-1:0]   maddr;
    logic             burst_start, burst_cancel;
    logic             pf_step, pf_busy, room;
    logic [CW:0]      occ, count_after;
    logic [CW-1:0]    f_count;
    logic [15:0]      f_head;
    logic             f_empty, f_full, f_push, f_pop;
    resp_t            rsp_q;

    assign sel     = host_sel_e'(host_sel);
    assign wr_data = host_wr && (sel == SEL_DATA);
    assign wr_addr = host_wr && (sel == SEL_ADDR);
    assign wr_cfg  = host_wr && (sel == SEL_CFG);
    assign wr_stat = host_wr && (sel == SEL_STAT);
    assign rd_data = host_rd && (sel == SEL_DATA);

    assign burst_start  = wr_cfg && host_wdata[CFG_RUN];
    assign burst_cancel = wr_cfg && !host_wdata[CFG_RUN];

    hdp_route #(.HI_W(HI_W)) u_route (
        .region   (cfg_q[CFG_REG_LO +: 3]),
        .addr     (addr_q),
        .hi       (hi_addr),
        .is_write (wr_data),
        .xp_chan  (xp_chan),
        .xp_dir   (xp_dir),
        .xp_unit  (xp_unit),
        .hit      (hit),
        .live     (live),
        .space    (space),
        .maddr    (maddr)
    );

    assign occ  = (CW+1)'(f_count) + (CW+1)'(rsp_q.valid);
    assign room = occ < (CW+1)'(DEPTH);

    hdp_prefetch u_prefetch (
        .clk    (clk),
        .rst    (rst),
        .start  (burst_start),
        .cancel (burst_cancel),
        .code   (code_q),
        .hold   (host_wr),
        .room   (room),
        .step   (pf_step),
        .busy   (pf_busy)
    );

    assign mem_req   = (wr_data || pf_step) && live;
    assign mem_we    = wr_data;
    assign mem_space = space;
    assign mem_addr  = maddr;
    assign mem_unit  = xp_unit;
    assign mem_wdata = host_wdata;

    assign f_push = rsp_q.valid;
    assign f_pop  = rd_data;

    hdp_fifo #(.DEPTH(DEPTH), .W(16)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (burst_cancel),
        .push  (f_push),
        .din   (rsp_q.live ? fmt_read(rsp_q.narrow, mem_rdata) : 16'h0000),
        .pop   (f_pop),
        .head  (f_head),
        .count (f_count),
        .empty (f_empty),
        .full  (f_full)
    );

    assign count_after = (CW+1)'(f_count) + (CW+1)'(f_push)
                       - (CW+1)'(f_pop && !f_empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid  <= pf_step;
            rsp_q.live   <= live;
            rsp_q.narrow <= (space == SP_EXT) && (xp_unit == UNIT_BYTE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cfg_q  <= '0;
            code_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_addr)
                addr_q <= host_wdata;
            else if ((wr_data || pf_step) && hit && cfg_q[CFG_AUTOINC])
                addr_q <= addr_q + 16'd1;
            if (wr_cfg)  cfg_q  <= host_wdata;
            if (wr_stat) code_q <= host_wdata[3:2];
            irq_q <= (wr_data && hit) || burst_start
                   || (rd_data && !burst_cancel && (count_after != '0));
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (sel)
            SEL_DATA: host_rdata = f_empty ? 16'h0000 : f_head;
            SEL_ADDR: host_rdata = addr_q;
            SEL_CFG:  host_rdata = cfg_q;
            default:  host_rdata = pack_status(!f_empty, f_full, code_q);
        endcase
    end

    assert_req_needs_region_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> hit);

    assert_peri_addr_cut_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_space == SP_PERI) |-> (mem_addr[MAW-1:PERI_AW] == '0));

    assert_read_not_with_write_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !host_wr);

    assert_no_prefetch_idle_R5: assert property (@(posedge clk) disable iff (rst)
        pf_step |-> pf_busy);

endmodule

// File: tb/test_hdp_data_port.sv
module test_hdp_data_port;
    import hdp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HI_W = 4;
    localparam int MAW  = 16 + HI_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]      host_sel = 2'd0;
    logic [15:0]     host_wdata = 16'h0;
    logic [15:0]     host_rdata;
    logic            irq;
    logic [HI_W-1:0] hi_addr = '0;
    logic [1:0]      xp_chan = 2'd0;
    logic            xp_dir = 1'b1;
    logic [1:0]      xp_unit = 2'd1;
    logic            mem_req, mem_we;
    logic [1:0]      mem_space;
    logic [MAW-1:0]  mem_addr;
    logic [1:0]      mem_unit;
    logic [15:0]     mem_wdata;
    logic [31:0]     mem_rdata = '0;

    int n_chk = 0, n_bad = 0, n_req = 0;
    bit done = 0;

    logic [1:0]     cap_space;
    logic [MAW-1:0] cap_addr;
    logic [15:0]    cap_wdata;
    logic           cap_we;

    hdp_data_port #(.HI_W(HI_W), .DEPTH(16)) i_hdp_data_port (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .hi_addr(hi_addr), .xp_chan(xp_chan), .xp_dir(xp_dir),
        .xp_unit(xp_unit), .mem_req(mem_req), .mem_we(mem_we),
        .mem_space(mem_space), .mem_addr(mem_addr), .mem_unit(mem_unit),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [1:0] sp, input logic [MAW-1:0] a);
        logic [15:0] lo;
        lo = (a[15:0] * 16'd7) ^ {12'h0, a[19:16]} ^ {sp, 14'h0};
        return {~lo, lo};
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            n_req++;
            if (!mem_we) mem_rdata <= pat(mem_space, mem_addr);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d,
                      output logic req, output logic irq_seen);
        @(negedge clk);
        host_wr = 1'b1; host_sel = s; host_wdata = d;
        #1;
        req = mem_req; cap_space = mem_space; cap_addr = mem_addr;
        cap_wdata = mem_wdata; cap_we = mem_we;
        @(negedge clk);
        host_wr = 1'b0;
        irq_seen = irq;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_sel = s;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic region_ok(input int r);
        return (r == 0) || (r == 1) || (r == 5) || (r == 7);
    endfunction

    function automatic logic [1:0] space_of(input int r);
        case (r)
            1: return 2'd1;
            5: return 2'd2;
            7: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic        q, ir;
        logic [15:0] v;
        int          base;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 mem_req", mem_req, 0);
        rd(SEL_STAT, v); chk("R1 status", v, 16'h0100);
        rd(SEL_ADDR, v); chk("R1 addr", v, 0);
        rd(SEL_CFG, v);  chk("R1 cfg", v, 0);

        // R2 R4 R11 R10 R3: write sweep over every region code
        hi_addr = 4'h9;
        xp_chan = 2'd0; xp_dir = 1'b1; xp_unit = 2'd1;
        for (int r = 0; r < 8; r++) begin
            wr(SEL_CFG, 16'(r << 12) | 16'h0002, q, ir);
            wr(SEL_ADDR, 16'h1234, q, ir);
            wr(SEL_DATA, 16'hABCD, q, ir);
            chk($sformatf("R2 req region %0d", r), q, region_ok(r));
            chk($sformatf("R10 irq region %0d", r), ir, region_ok(r));
            if (region_ok(r)) begin
                chk($sformatf("R2 space region %0d", r), cap_space, space_of(r));
                chk($sformatf("R4 addr region %0d", r), cap_addr,
                    (r == 1) ? 20'h00234 : 20'h91234);
                chk("R11 wdata", cap_wdata, 16'hABCD);
                chk("R11 we", cap_we, 1);
            end
            rd(SEL_ADDR, v);
            chk($sformatf("R3 addr after region %0d", r), v,
                region_ok(r) ? 16'h1235 : 16'h1234);
        end

        // R3 wrap and no auto-increment
        wr(SEL_CFG, 16'h0002, q, ir);
        wr(SEL_ADDR, 16'hFFFF, q, ir);
        wr(SEL_DATA, 16'h0001, q, ir);
        rd(SEL_ADDR, v); chk("R3 wrap", v, 16'h0000);
        wr(SEL_CFG, 16'h0000, q, ir);
        wr(SEL_ADDR, 16'h0040, q, ir);
        wr(SEL_DATA, 16'h0001, q, ir);
        rd(SEL_ADDR, v); chk("R3 hold", v, 16'h0040);

        // R9 external write gating
        wr(SEL_CFG, 16'h7002, q, ir);
        wr(SEL_ADDR, 16'h0200, q, ir);
        xp_chan = 2'd1;
        wr(SEL_DATA, 16'h0005, q, ir); chk("R9 wrong channel", q, 0);
        xp_chan = 2'd0; xp_dir = 1'b0;
        wr(SEL_DATA, 16'h0005, q, ir); chk("R9 wrong dir", q, 0);
        xp_dir = 1'b1; xp_unit = 2'd3;
        wr(SEL_DATA, 16'h0005, q, ir); chk("R9 unit 3", q, 0);
        rd(SEL_ADDR, v); chk("R9 addr still moves", v, 16'h0203);
        xp_unit = 2'd1;

        // R5 R6 R7 R8 R10: burst codes on data memory
        hi_addr = 4'h3;
        for (int code = 0; code < 4; code++) begin
            int len, n;
            len = (code == 0) ? 1 : (code == 1) ? 8 : 16;
            n   = (code == 3) ? 24 : len;
            wr(SEL_STAT, 16'(code << 2), q, ir);
            wr(SEL_ADDR, 16'h0100, q, ir);
            wr(SEL_CFG, 16'h0012, q, ir);
            chk($sformatf("R10 irq start code %0d", code), ir, 1);
            repeat (40) @(negedge clk);
            rd(SEL_STAT, v);
            chk($sformatf("R8 status full code %0d", code), v,
                16'h0141 | 16'(code << 2) | ((code >= 2) ? 16'h0020 : 16'h0));
            for (int i = 0; i < n; i++) begin
                rd(SEL_DATA, v);
                chk($sformatf("R6 R7 code %0d word %0d", code, i), v,
                    pat(2'd0, {4'h3, 16'h0100 + 16'(i)}) & 32'hFFFF);
            end
            if (code != 3) begin
                rd(SEL_DATA, v); chk($sformatf("R7 empty read code %0d", code), v, 0);
                rd(SEL_STAT, v); chk($sformatf("R8 empty code %0d", code), v,
                                     16'h0100 | 16'(code << 2));
            end
            wr(SEL_CFG, 16'h0002, q, ir);
            rd(SEL_STAT, v); chk($sformatf("R5 flushed code %0d", code), v,
                                 16'h0100 | 16'(code << 2));
        end

        // R5 cancel mid-burst
        wr(SEL_STAT, 16'h0008, q, ir);
        wr(SEL_ADDR, 16'h0300, q, ir);
        wr(SEL_CFG, 16'h0012, q, ir);
        repeat (30) @(negedge clk);
        rd(SEL_DATA, v); chk("R5 first word", v, pat(2'd0, 20'h30300) & 32'hFFFF);
        wr(SEL_CFG, 16'h0002, q, ir);
        rd(SEL_STAT, v); chk("R5 cancel status", v, 16'h0108);
        rd(SEL_DATA, v); chk("R5 cancel read", v, 0);

        // R9 external reads: byte, word, gated
        wr(SEL_STAT, 16'h0004, q, ir);
        for (int u = 0; u < 3; u++) begin
            xp_chan = 2'd0;
            xp_dir  = (u == 2);
            xp_unit = (u == 0) ? 2'd0 : 2'd2;
            wr(SEL_ADDR, 16'h0500, q, ir);
            base = n_req;
            wr(SEL_CFG, 16'h7012, q, ir);
            repeat (20) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                logic [31:0] p;
                p = pat(2'd3, {4'h3, 16'h0500 + 16'(i)});
                rd(SEL_DATA, v);
                chk($sformatf("R9 ext read mode %0d word %0d", u, i), v,
                    (u == 0) ? {8'h0, p[7:0]} : (u == 1) ? p[15:0] : 16'h0);
            end
            chk($sformatf("R9 ext request count mode %0d", u), n_req - base, (u == 2) ? 0 : 8);
            wr(SEL_CFG, 16'h0000, q, ir);
        end
        xp_dir = 1'b1; xp_unit = 2'd1;

        // R2 peripheral burst with address cut
        wr(SEL_ADDR, 16'hF805, q, ir);
        wr(SEL_CFG, 16'h1012, q, ir);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a;
            a = 16'hF805 + 16'(i);
            rd(SEL_DATA, v);
            chk($sformatf("R2 peri word %0d", i), v, pat(2'd1, 20'(a[10:0])) & 32'hFFFF);
        end
        wr(SEL_CFG, 16'h0000, q, ir);

        // R2 invalid region burst yields zeros without requests
        wr(SEL_ADDR, 16'h0100, q, ir);
        base = n_req;
        wr(SEL_CFG, 16'h2012, q, ir);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd(SEL_DATA, v);
            chk($sformatf("R2 ignored region word %0d", i), v, 0);
        end
        chk("R2 ignored region requests", n_req - base, 0);
        rd(SEL_ADDR, v); chk("R2 ignored region addr", v, 16'h0100);
        wr(SEL_CFG, 16'h0000, q, ir);
        chk("R10 no irq on cancel", ir, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule